// File: doc/BRIEF.md
# Descriptor-Chained DMA Channel

This block is one DMA channel that copies words from a source address to a destination address, one beat at a time, over a single request/acknowledge memory master port. A small register window holds the live source and destination pointers, the pointer to the next descriptor, a control word (beat count, burst codes, access widths, increment enables, protection bits, end-of-descriptor interrupt enable) and a configuration word (enable, peripheral numbers, flow type, interrupt masks, lock, halt, active).

When the beat count of the current descriptor runs out and the next-descriptor pointer is non-zero, the channel fetches four words from that pointer over the same port and carries on without software. A zero pointer ends the chain: the channel clears its own enable. Transfers that touch a peripheral wait, before every burst, for that peripheral's request line; memory-to-memory transfers do not wait. Setting halt stops new bursts, and the active status bit tells software when the last access has retired.

Top module: `lldma_channel`

## Requirements
- R1: Register word offsets on `reg_addr` are 0 source, 1 destination, 2 next-descriptor pointer, 3 control, 4 configuration, 5 status, 6 flag clear. Offsets 0 to 3 take software writes only while the channel is idle and read back what was written. All registers read zero after reset. Configuration bit 17 reads as the active status and is not writable.
- R2: Each beat reads the word at the source address (`m_we`=0, `m_size` = source width code) and then writes that data to the destination address (`m_we`=1, `m_size` = destination width code). Width code 0 steps an address by 1, code 1 steps it by 2 and code 2 steps it by 4, applied only when control bit 26 (source) or bit 27 (destination) is set. Control bits 11:0 count down by one per completed beat.
- R3: Once `m_req` is raised it stays high, with `m_addr`, `m_we` and `m_wdata` unchanged, until the cycle in which `m_ack` is high.
- R4: Configuration bits 13:11 select the flow: 0 memory to memory, 1 memory to peripheral, 2 peripheral to memory, 3 peripheral to peripheral. With a peripheral source (flows 2 and 3) the channel waits on `per_req` of the source peripheral number (bits 5:1) and uses the source burst code (control bits 14:12). With flow 1 it waits on the destination peripheral number (bits 10:6) and uses the destination burst code (bits 17:15). Burst codes 0 to 7 mean 1, 4, 8, 16, 32, 64, 128 and 256 beats, cut short by the remaining count. Flow 0 runs without waiting. Other request lines have no effect.
- R5: When the count reaches zero and the next-descriptor pointer P is non-zero, the channel reads P, P+4, P+8 and P+12 into source, destination, pointer and control, and continues. When P is zero it clears configuration bit 0 and goes idle.
- R6: At the end of every descriptor whose control bit 31 is set, status bit 0 is set. `irq_tc` is status bit 0 AND configuration bit 15.
- R7: An access acknowledged with `m_err` high sets status bit 1, clears configuration bit 0 and issues no further access. `irq_err` is status bit 1 AND configuration bit 14.
- R8: Writing offset 6 clears status bit 0 where data bit 0 is 1 and status bit 1 where data bit 1 is 1; zero bits leave the flags unchanged.
- R9: While configuration bit 18 (halt) is set, no new burst starts and peripheral requests have no effect; active drops once no access is pending. Clearing halt lets the channel resume.
- R10: Enabling the channel with a control count of zero treats the descriptor as already finished: the end-of-descriptor flag and chaining rules of R5 and R6 apply with no data access.
- R11: `m_prot` carries control bits 30:28 and `m_lock` carries configuration bit 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| m_req | output | 1 | Memory access request |
| m_we | output | 1 | Access is a write |
| m_addr | output | 32 | Access byte address |
| m_wdata | output | 32 | Write data |
| m_size | output | 2 | Access width code |
| m_prot | output | 3 | Protection bits of the current descriptor |
| m_lock | output | 1 | Locked-access indication |
| m_ack | input | 1 | Access completes this cycle |
| m_rdata | input | 32 | Read data, valid with `m_ack` |
| m_err | input | 1 | Error response, valid with `m_ack` |
| per_req | input | NPER | Per-peripheral burst request lines |
| irq_tc | output | 1 | End-of-descriptor interrupt |
| irq_err | output | 1 | Error interrupt |

## Verification
The properties assume the memory side answers each access with a single-cycle `m_ack` and drives `m_err` only together with it, and that software does not rewrite the configuration in the same cycle as an error response. The bench's memory responder keeps to this by raising `m_ack` for exactly one cycle per request, sometimes after a wait cycle, and its register writes happen only while the channel is idle, waiting, or after completion has been polled. Peripheral request lines are pulsed for one cycle at a time, only while the channel is parked between bursts.

// File: rtl/lldma_pkg.sv
package lldma_pkg;

  localparam int WORD_W = 32;
  localparam int CNT_W  = 12;

  localparam logic [2:0] RA_SRC  = 3'd0;
  localparam logic [2:0] RA_DST  = 3'd1;
  localparam logic [2:0] RA_LINK = 3'd2;
  localparam logic [2:0] RA_CTRL = 3'd3;
  localparam logic [2:0] RA_CFG  = 3'd4;
  localparam logic [2:0] RA_STAT = 3'd5;
  localparam logic [2:0] RA_CLR  = 3'd6;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RD, ST_WR, ST_END, ST_FETCH, ST_NEXT
  } seq_state_e;

  typedef struct packed {
    logic        tc_ie;
    logic [2:0]  prot;
    logic        dinc;
    logic        sinc;
    logic [1:0]  spare;
    logic [2:0]  dwid;
    logic [2:0]  swid;
    logic [2:0]  dburst;
    logic [2:0]  sburst;
    logic [CNT_W-1:0] cnt;
  } ctrl_t;

  typedef struct packed {
    logic [12:0] spare;
    logic        halt;
    logic        active;
    logic        lock;
    logic        tc_mask;
    logic        err_mask;
    logic [2:0]  flow;
    logic [4:0]  dper;
    logic [4:0]  sper;
    logic        en;
  } cfg_t;

  function automatic logic [8:0] burst_beats(input logic [2:0] code);
    if (code == 3'd0) return 9'd1;
    return 9'd1 << ({1'b0, code} + 4'd1);
  endfunction

  function automatic logic [2:0] addr_step(input logic [2:0] wid);
    case (wid)
      3'd0:    return 3'd1;
      3'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [1:0] size_code(input logic [2:0] wid);
    return (wid > 3'd2) ? 2'd2 : wid[1:0];
  endfunction

endpackage

// File: rtl/lldma_regs.sv
module lldma_regs
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_we,
  input  logic [2:0]        sw_addr,
  input  logic [WORD_W-1:0] sw_wdata,
  output logic [WORD_W-1:0] sw_rdata,
  input  logic              eng_idle,
  input  logic              eng_active,
  input  logic              beat_adv,
  input  logic              ld_en,
  input  logic [1:0]        ld_idx,
  input  logic [WORD_W-1:0] ld_data,
  input  logic              tc_set,
  input  logic              err_set,
  input  logic              en_clr,
  output logic [WORD_W-1:0] src_q,
  output logic [WORD_W-1:0] dst_q,
  output logic [WORD_W-1:0] link_q,
  output ctrl_t             ctrl_q,
  output cfg_t              cfg_q,
  output logic              tc_q,
  output logic              err_q
);

  logic [WORD_W-1:0] src_d, dst_d, link_d;
  ctrl_t             ctrl_d;
  cfg_t              cfg_d;
  logic              tc_d, err_d;
  logic              wr_path;
  cfg_t              cfg_view;

  assign wr_path = sw_we && eng_idle;

  always_comb begin
    src_d  = src_q;
    dst_d  = dst_q;
    link_d = link_q;
    ctrl_d = ctrl_q;
    cfg_d  = cfg_q;
    tc_d   = tc_q;
    err_d  = err_q;

    if (wr_path) begin
      case (sw_addr)
        RA_SRC:  src_d  = sw_wdata;
        RA_DST:  dst_d  = sw_wdata;
        RA_LINK: link_d = sw_wdata;
        RA_CTRL: ctrl_d = ctrl_t'(sw_wdata);
        default: ;
      endcase
    end

    if (beat_adv) begin
      src_d      = src_q + (ctrl_q.sinc ? WORD_W'(addr_step(ctrl_q.swid)) : '0);
      dst_d      = dst_q + (ctrl_q.dinc ? WORD_W'(addr_step(ctrl_q.dwid)) : '0);
      ctrl_d.cnt = ctrl_q.cnt - 1'b1;
    end

    if (ld_en) begin
      case (ld_idx)
        2'd0:    src_d  = ld_data;
        2'd1:    dst_d  = ld_data;
        2'd2:    link_d = ld_data;
        default: ctrl_d = ctrl_t'(ld_data);
      endcase
    end

    if (sw_we && sw_addr == RA_CFG) begin
      cfg_d        = cfg_t'(sw_wdata);
      cfg_d.active = 1'b0;
    end
    if (en_clr) cfg_d.en = 1'b0;

    if (sw_we && sw_addr == RA_CLR) begin
      if (sw_wdata[0]) tc_d  = 1'b0;
      if (sw_wdata[1]) err_d = 1'b0;
    end
    if (tc_set)  tc_d  = 1'b1;
    if (err_set) err_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= '0;
      dst_q  <= '0;
      link_q <= '0;
      ctrl_q <= '0;
      cfg_q  <= '0;
      tc_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      src_q  <= src_d;
      dst_q  <= dst_d;
      link_q <= link_d;
      ctrl_q <= ctrl_d;
      cfg_q  <= cfg_d;
      tc_q   <= tc_d;
      err_q  <= err_d;
    end
  end

  always_comb begin
    cfg_view        = cfg_q;
    cfg_view.active = eng_active;
    case (sw_addr)
      RA_SRC:  sw_rdata = src_q;
      RA_DST:  sw_rdata = dst_q;
      RA_LINK: sw_rdata = link_q;
      RA_CTRL: sw_rdata = ctrl_q;
      RA_CFG:  sw_rdata = cfg_view;
      RA_STAT: sw_rdata = {{(WORD_W-2){1'b0}}, err_q, tc_q};
      default: sw_rdata = '0;
    endcase
  end

endmodule

// File: rtl/lldma_gate.sv
module lldma_gate
  import lldma_pkg::*;
#(
  parameter int NPER = 32
) (
  input  cfg_t             cfg,
  input  ctrl_t            ctrl,
  input  logic [NPER-1:0]  per_req,
  output logic             go,
  output logic [CNT_W-1:0] burst_len
);

  localparam int SEL_SPAN = 32;

  logic              src_per, dst_per, need;
  logic [4:0]        sel;
  logic [2:0]        code;
  logic [SEL_SPAN-1:0] req_ext;
  logic [CNT_W-1:0]  full_len;

  always_comb begin
    src_per = (cfg.flow == 3'd2) || (cfg.flow == 3'd3);
    dst_per = (cfg.flow == 3'd1);
    need    = src_per || dst_per;
    sel     = src_per ? cfg.sper : cfg.dper;
    code    = dst_per ? ctrl.dburst : ctrl.sburst;
    req_ext = '0;
    req_ext[NPER-1:0] = per_req;
    go      = !need || req_ext[sel];
    full_len  = CNT_W'(burst_beats(code));
    burst_len = (ctrl.cnt < full_len) ? ctrl.cnt : full_len;
  end

endmodule

// File: rtl/lldma_seq.sv
module lldma_seq
  import lldma_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              halt,
  input  logic              go,
  input  logic [CNT_W-1:0]  burst_len,
  input  ctrl_t             ctrl,
  input  logic [WORD_W-1:0] src_q,
  input  logic [WORD_W-1:0] dst_q,
  input  logic [WORD_W-1:0] link_q,
  output logic              m_req,
  output logic              m_we,
  output logic [WORD_W-1:0] m_addr,
  output logic [WORD_W-1:0] m_wdata,
  output logic [1:0]        m_size,
  input  logic              m_ack,
  input  logic [WORD_W-1:0] m_rdata,
  input  logic              m_err,
  output logic              beat_adv,
  output logic              ld_en,
  output logic [1:0]        ld_idx,
  output logic [WORD_W-1:0] ld_data,
  output logic              tc_set,
  output logic              err_set,
  output logic              en_clr,
  output logic              idle,
  output logic              active
);

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  bcnt_q, bcnt_d;
  logic [1:0]        idx_q, idx_d;
  logic [WORD_W-1:0] data_q, data_d;
  logic [WORD_W-1:0] base_q, base_d;
  logic              cnt_zero;

  assign cnt_zero = (ctrl.cnt == '0);

  always_comb begin
    st_d     = st_q;
    bcnt_d   = bcnt_q;
    idx_d    = idx_q;
    data_d   = data_q;
    base_d   = base_q;
    m_req    = 1'b0;
    m_we     = 1'b0;
    m_addr   = src_q;
    m_size   = size_code(ctrl.swid);
    beat_adv = 1'b0;
    ld_en    = 1'b0;
    ld_idx   = idx_q;
    ld_data  = m_rdata;
    tc_set   = 1'b0;
    err_set  = 1'b0;
    en_clr   = 1'b0;

    case (st_q)
      ST_IDLE, ST_NEXT: begin
        if (!en)          st_d = ST_IDLE;
        else if (cnt_zero) st_d = ST_END;
        else              st_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (!en) st_d = ST_IDLE;
        else if (!halt && go) begin
          bcnt_d = burst_len;
          st_d   = ST_RD;
        end
      end
      ST_RD: begin
        m_req = 1'b1;
        if (m_ack) begin
          if (m_err) begin
            err_set = 1'b1;
            en_clr  = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            data_d = m_rdata;
            st_d   = ST_WR;
          end
        end
      end
      ST_WR: begin
        m_req  = 1'b1;
        m_we   = 1'b1;
        m_addr = dst_q;
        m_size = size_code(ctrl.dwid);
        if (m_ack) begin
          if (m_err) begin
            err_set = 1'b1;
            en_clr  = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            beat_adv = 1'b1;
            bcnt_d   = bcnt_q - 1'b1;
            if (ctrl.cnt == CNT_W'(1))    st_d = ST_END;
            else if (bcnt_q == CNT_W'(1)) st_d = ST_WAIT;
            else                          st_d = ST_RD;
          end
        end
      end
      ST_END: begin
        tc_set = ctrl.tc_ie;
        if (link_q == '0) begin
          en_clr = 1'b1;
          st_d   = ST_IDLE;
        end else begin
          base_d = link_q;
          idx_d  = 2'd0;
          st_d   = ST_FETCH;
        end
      end
      ST_FETCH: begin
        m_req  = 1'b1;
        m_addr = base_q + {{(WORD_W-4){1'b0}}, idx_q, 2'b00};
        m_size = 2'd2;
        if (m_ack) begin
          if (m_err) begin
            err_set = 1'b1;
            en_clr  = 1'b1;
            st_d    = ST_IDLE;
          end else begin
            ld_en = 1'b1;
            idx_d = idx_q + 1'b1;
            if (idx_q == 2'd3) st_d = ST_NEXT;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bcnt_q <= '0;
      idx_q  <= '0;
      data_q <= '0;
      base_q <= '0;
    end else begin
      st_q   <= st_d;
      bcnt_q <= bcnt_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      base_q <= base_d;
    end
  end

  assign m_wdata = data_q;
  assign idle    = (st_q == ST_IDLE);
  assign active  = (st_q != ST_IDLE) && !((st_q == ST_WAIT) && (halt || !en));

endmodule

// File: rtl/lldma_channel.sv
module lldma_channel
  import lldma_pkg::*;
#(
  parameter int NPER = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req,
  output logic              m_we,
  output logic [31:0]       m_addr,
  output logic [31:0]       m_wdata,
  output logic [1:0]        m_size,
  output logic [2:0]        m_prot,
  output logic              m_lock,
  input  logic              m_ack,
  input  logic [31:0]       m_rdata,
  input  logic              m_err,
  input  logic [NPER-1:0]   per_req,
  output logic              irq_tc,
  output logic              irq_err
);

  logic [1:0]        rst_pipe;
  logic              rst_sn;
  logic [WORD_W-1:0] src_q, dst_q, link_q;
  ctrl_t             ctrl_q;
  cfg_t              cfg_q;
  logic              tc_q, err_q;
  logic              beat_adv, ld_en, tc_set, err_set, en_clr, idle, active;
  logic [1:0]        ld_idx;
  logic [WORD_W-1:0] ld_data;
  logic              go;
  logic [CNT_W-1:0]  burst_len;
  logic              cfg_en, cfg_tcm, cfg_erm;
  logic [CNT_W-1:0]  ctrl_cnt;
  logic              sig_unused;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sn = rst_pipe[1];

  lldma_regs u_regs (
    .clk(clk), .rst_n(rst_sn),
    .sw_we(reg_we), .sw_addr(reg_addr), .sw_wdata(reg_wdata), .sw_rdata(reg_rdata),
    .eng_idle(idle), .eng_active(active),
    .beat_adv(beat_adv), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .tc_set(tc_set), .err_set(err_set), .en_clr(en_clr),
    .src_q(src_q), .dst_q(dst_q), .link_q(link_q), .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .tc_q(tc_q), .err_q(err_q)
  );

  lldma_gate #(.NPER(NPER)) u_gate (
    .cfg(cfg_q), .ctrl(ctrl_q), .per_req(per_req), .go(go), .burst_len(burst_len)
  );

  lldma_seq u_seq (
    .clk(clk), .rst_n(rst_sn),
    .en(cfg_q.en), .halt(cfg_q.halt), .go(go), .burst_len(burst_len), .ctrl(ctrl_q),
    .src_q(src_q), .dst_q(dst_q), .link_q(link_q),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_size(m_size),
    .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err),
    .beat_adv(beat_adv), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .tc_set(tc_set), .err_set(err_set), .en_clr(en_clr), .idle(idle), .active(active)
  );

  assign irq_tc   = tc_q  && cfg_q.tc_mask;
  assign irq_err  = err_q && cfg_q.err_mask;
  assign m_prot   = ctrl_q.prot;
  assign m_lock   = cfg_q.lock;
  assign cfg_en   = cfg_q.en;
  assign cfg_tcm  = cfg_q.tc_mask;
  assign cfg_erm  = cfg_q.err_mask;
  assign ctrl_cnt = ctrl_q.cnt;
  assign sig_unused = ^{cfg_q.spare, cfg_q.active, ctrl_q.spare, cfg_tcm, cfg_erm};

endmodule

// File: rtl/lldma_chk.sv
module lldma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        m_req,
  input logic        m_ack,
  input logic        m_err,
  input logic        m_we,
  input logic [31:0] m_addr,
  input logic [31:0] m_wdata,
  input logic        reg_we,
  input logic [2:0]  reg_addr,
  input logic        cfg_en,
  input logic [11:0] ctrl_cnt,
  input logic        beat_adv,
  input logic        active,
  input logic        tc_q,
  input logic        err_q
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && !m_ack |=> m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)); // R3

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    beat_adv |=> ctrl_cnt == $past(ctrl_cnt) - 12'd1); // R2

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    m_req && m_ack && m_err && !(reg_we && reg_addr == 3'd4) |=> !cfg_en && !m_req && err_q); // R7

  AST_TC_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tc_q) |-> $past(ctrl_cnt) == 12'd0); // R6

  AST_REQ_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    m_req |-> active); // R9

  AST_REQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_req) |-> cfg_en); // R5

endmodule

bind lldma_channel lldma_chk u_chk (
  .clk(clk), .rst_n(rst_sn),
  .m_req(m_req), .m_ack(m_ack), .m_err(m_err), .m_we(m_we),
  .m_addr(m_addr), .m_wdata(m_wdata),
  .reg_we(reg_we), .reg_addr(reg_addr),
  .cfg_en(cfg_en), .ctrl_cnt(ctrl_cnt), .beat_adv(beat_adv),
  .active(active), .tc_q(tc_q), .err_q(err_q)
);

// File: tb/tb_lldma_channel.sv
module tb_lldma_channel;

  localparam int NPER = 32;

  typedef struct {
    logic [31:0] a;
    logic [31:0] d;
    logic [1:0]  s;
  } xfer_t;

  logic clk, rst_n;
  logic reg_we;
  logic [2:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic m_req, m_we, m_lock, m_ack, m_err;
  logic [31:0] m_addr, m_wdata, m_rdata;
  logic [1:0] m_size;
  logic [2:0] m_prot;
  logic [NPER-1:0] per_req;
  logic irq_tc, irq_err;

  logic [31:0] mem [0:255];
  xfer_t exp_q[$];
  xfer_t obs_q[$];
  int    n_run, n_fail, wr_cnt, lat, stab_viol;
  logic [31:0] err_addr;
  logic [2:0]  seen_prot;
  logic        seen_lock;
  bit          finished;

  lldma_channel #(.NPER(NPER)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_req(m_req), .m_we(m_we), .m_addr(m_addr), .m_wdata(m_wdata), .m_size(m_size),
    .m_prot(m_prot), .m_lock(m_lock), .m_ack(m_ack), .m_rdata(m_rdata), .m_err(m_err),
    .per_req(per_req), .irq_tc(irq_tc), .irq_err(irq_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] mk_ctrl(input int cnt, input int sb, input int db, input int sw,
      input int dw, input bit si, input bit di, input logic [2:0] prot, input bit tcie);
    return {tcie, prot, di, si, 2'b00, 3'(dw), 3'(sw), 3'(db), 3'(sb), 12'(cnt)};
  endfunction

  function automatic logic [31:0] mk_cfg(input bit en, input int sp, input int dp, input int flow,
      input bit erm, input bit tcm, input bit lock, input bit halt);
    return {13'b0, halt, 1'b0, lock, tcm, erm, 3'(flow), 5'(dp), 5'(sp), en};
  endfunction

  function automatic int step_of(input int w);
    return (w == 0) ? 1 : (w == 1) ? 2 : 4;
  endfunction

  task automatic push_exp(input logic [31:0] src, input logic [31:0] dst, input int cnt,
      input int sw, input int dw, input bit si, input bit di);
    for (int i = 0; i < cnt; i++) begin
      xfer_t x;
      logic [31:0] sa;
      sa  = src + (si ? 32'(i * step_of(sw)) : 32'd0);
      x.a = dst + (di ? 32'(i * step_of(dw)) : 32'd0);
      x.d = mem[sa[9:2]];
      x.s = 2'(dw);
      exp_q.push_back(x);
    end
  endtask

  task automatic reg_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int i = 0; i < 3000; i++) begin
      reg_rd(3'd4, v);
      if (!v[0] && !v[17]) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse(input int line);
    @(negedge clk);
    per_req = '0;
    per_req[line] = 1'b1;
    @(negedge clk);
    per_req = '0;
  endtask

  // memory responder
  initial begin
    logic [31:0] held;
    int wcnt;
    m_ack = 1'b0; m_err = 1'b0; m_rdata = '0; wcnt = 0; held = '0;
    forever begin
      @(negedge clk);
      if (m_ack) begin
        m_ack = 1'b0; m_err = 1'b0;
      end else if (m_req) begin
        if (wcnt == 0) held = m_addr;
        else if (m_addr != held) stab_viol++;
        if (wcnt < lat) wcnt++;
        else begin
          wcnt = 0;
          m_ack = 1'b1;
          m_err = (m_addr == err_addr);
          m_rdata = mem[m_addr[9:2]];
          if (m_we && !m_err) begin
            xfer_t x;
            x.a = m_addr; x.d = m_wdata; x.s = m_size;
            mem[m_addr[9:2]] = m_wdata;
            seen_prot = m_prot;
            seen_lock = m_lock;
            obs_q.push_back(x);
          end
        end
      end
    end
  end

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (obs_q.size() > 0) begin
        xfer_t o, e;
        o = obs_q.pop_front();
        wr_cnt++;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected write addr", o.a, 32'hFFFF_FFFF);
        end else begin
          e = exp_q.pop_front();
          chk(o.a == e.a, "R2 write addr", o.a, e.a);
          chk(o.d == e.d, "R2 write data", o.d, e.d);
          chk(o.s == e.s, "R2 write size", 32'(o.s), 32'(e.s));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base;
    n_run = 0; n_fail = 0; wr_cnt = 0; lat = 0; stab_viol = 0;
    err_addr = 32'hFFFF_FFFF; finished = 0; seen_prot = '0; seen_lock = 1'b0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; per_req = '0; rst_n = 0;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA500_0000 + 32'(i * 7);
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    // reset state R1
    for (int a = 0; a < 6; a++) begin
      reg_rd(3'(a), v);
      chk(v == 32'd0, "R1 reset register", v, 32'd0);
    end
    chk(!m_req && !irq_tc && !irq_err, "R1 reset outputs", {29'b0, m_req, irq_tc, irq_err}, 32'd0);

    // R1 readback while idle, active bit not writable
    reg_wr(3'd0, 32'h0000_1234);
    reg_wr(3'd2, 32'h0000_0ABC);
    reg_rd(3'd0, v); chk(v == 32'h1234, "R1 src readback", v, 32'h1234);
    reg_rd(3'd2, v); chk(v == 32'h0ABC, "R1 link readback", v, 32'h0ABC);
    reg_wr(3'd4, 32'h0002_0000);
    reg_rd(3'd4, v); chk(v == 32'd0, "R1 active read-only", v, 32'd0);

    // R2 R3 R6 R11: memory to memory, one descriptor, wait cycles on port
    lat = 1;
    push_exp(32'h40, 32'h200, 4, 2, 2, 1, 1);
    reg_wr(3'd0, 32'h40);
    reg_wr(3'd1, 32'h200);
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, mk_ctrl(4, 0, 0, 2, 2, 1, 1, 3'b101, 1));
    base = wr_cnt;
    reg_wr(3'd4, mk_cfg(1, 0, 0, 0, 0, 1, 1, 0));
    wait_done();
    chk(wr_cnt - base == 4, "R2 beat count", 32'(wr_cnt - base), 32'd4);
    reg_rd(3'd0, v); chk(v == 32'h50, "R2 src advanced", v, 32'h50);
    reg_rd(3'd1, v); chk(v == 32'h210, "R2 dst advanced", v, 32'h210);
    reg_rd(3'd3, v); chk(v[11:0] == 12'd0, "R2 count exhausted", v, 32'd0);
    reg_rd(3'd5, v); chk(v == 32'd1, "R6 tc flag", v, 32'd1);
    chk(irq_tc == 1'b1, "R6 irq_tc with mask", 32'(irq_tc), 32'd1);
    chk(seen_prot == 3'b101, "R11 prot passthrough", 32'(seen_prot), 32'd5);
    chk(seen_lock == 1'b1, "R11 lock passthrough", 32'(seen_lock), 32'd1);
    chk(stab_viol == 0, "R3 request held stable", 32'(stab_viol), 32'd0);
    lat = 0;

    // R8 write one to clear
    reg_wr(3'd6, 32'd0);
    reg_rd(3'd5, v); chk(v == 32'd1, "R8 zero write no effect", v, 32'd1);
    reg_wr(3'd6, 32'd1);
    reg_rd(3'd5, v); chk(v == 32'd0, "R8 tc cleared", v, 32'd0);
    chk(irq_tc == 1'b0, "R8 irq_tc dropped", 32'(irq_tc), 32'd0);

    // R10: zero count, no link
    base = wr_cnt;
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, mk_ctrl(0, 0, 0, 2, 2, 1, 1, 3'b000, 1));
    reg_wr(3'd4, mk_cfg(1, 0, 0, 0, 0, 0, 0, 0));
    wait_done();
    chk(wr_cnt == base, "R10 no data access", 32'(wr_cnt - base), 32'd0);
    reg_rd(3'd5, v); chk(v == 32'd1, "R10 tc at empty descriptor", v, 32'd1);
    chk(irq_tc == 1'b0, "R6 irq_tc masked", 32'(irq_tc), 32'd0);
    reg_wr(3'd6, 32'd1);

    // R5 chaining from a zero-count start descriptor
    mem[64] = 32'h80;  mem[65] = 32'h240; mem[66] = 32'h110;
    mem[67] = mk_ctrl(3, 0, 0, 2, 2, 1, 1, 3'b000, 0);
    mem[68] = 32'h90;  mem[69] = 32'h280; mem[70] = 32'h0;
    mem[71] = mk_ctrl(2, 0, 0, 0, 0, 0, 1, 3'b000, 1);
    push_exp(32'h80, 32'h240, 3, 2, 2, 1, 1);
    push_exp(32'h90, 32'h280, 2, 0, 0, 0, 1);
    base = wr_cnt;
    reg_wr(3'd2, 32'h100);
    reg_wr(3'd3, mk_ctrl(0, 0, 0, 2, 2, 1, 1, 3'b000, 0));
    reg_wr(3'd4, mk_cfg(1, 0, 0, 0, 0, 1, 0, 0));
    wait_done();
    chk(wr_cnt - base == 5, "R5 beats over chain", 32'(wr_cnt - base), 32'd5);
    reg_rd(3'd2, v); chk(v == 32'h0, "R5 null link loaded", v, 32'h0);
    reg_rd(3'd1, v); chk(v == 32'h282, "R5 byte-step dst", v, 32'h282);
    reg_rd(3'd0, v); chk(v == 32'h90, "R5 src held without increment", v, 32'h90);
    reg_rd(3'd4, v); chk(v[0] == 1'b0, "R5 enable cleared at chain end", v, 32'd0);
    reg_rd(3'd5, v); chk(v == 32'd1, "R6 tc once at last descriptor", v, 32'd1);
    reg_wr(3'd6, 32'd1);

    // R4 memory to peripheral 5, burst code 1 (4 beats), count 6
    push_exp(32'h40, 32'h300, 6, 2, 2, 1, 0);
    base = wr_cnt;
    reg_wr(3'd0, 32'h40);
    reg_wr(3'd1, 32'h300);
    reg_wr(3'd2, 32'h0);
    reg_wr(3'd3, mk_ctrl(6, 0, 1, 2, 2, 1, 0, 3'b000, 0));
    reg_wr(3'd4, mk_cfg(1, 0, 5, 1, 0, 0, 0, 0));
    repeat (20) @(negedge clk);
    chk(wr_cnt == base, "R4 waits for request", 32'(wr_cnt - base), 32'd0);
    reg_rd(3'd4, v); chk(v[17] == 1'b1, "R4 active while waiting", v, 32'h1);
    pulse(5);
    repeat (30) @(negedge clk);
    chk(wr_cnt - base == 4, "R4 one burst per request", 32'(wr_cnt - base), 32'd4);
    pulse(4);
    repeat (20) @(negedge clk);
    chk(wr_cnt - base == 4, "R4 other line ignored", 32'(wr_cnt - base), 32'd4);
    pulse(5);
    wait_done();
    chk(wr_cnt - base == 6, "R4 last burst truncated", 32'(wr_cnt - base), 32'd6);

    // R9 halt
    push_exp(32'h40, 32'h300, 4, 2, 2, 1, 0);
    base = wr_cnt;
    reg_wr(3'd0, 32'h40);
    reg_wr(3'd3, mk_ctrl(8, 0, 1, 2, 2, 1, 0, 3'b000, 0));
    reg_wr(3'd4, mk_cfg(1, 0, 5, 1, 0, 0, 0, 1));
    repeat (10) @(negedge clk);
    reg_rd(3'd4, v); chk(v[17] == 1'b0, "R9 active low when halted", v, 32'h0);
    pulse(5);
    repeat (20) @(negedge clk);
    chk(wr_cnt == base, "R9 request ignored in halt", 32'(wr_cnt - base), 32'd0);
    reg_wr(3'd4, mk_cfg(1, 0, 5, 1, 0, 0, 0, 0));
    pulse(5);
    repeat (30) @(negedge clk);
    chk(wr_cnt - base == 4, "R9 resumes after halt cleared", 32'(wr_cnt - base), 32'd4);
    reg_wr(3'd4, mk_cfg(1, 0, 5, 1, 0, 0, 0, 1));
    pulse(5);
    repeat (20) @(negedge clk);
    chk(wr_cnt - base == 4, "R9 halted again", 32'(wr_cnt - base), 32'd4);
    reg_rd(3'd4, v); chk(v[17] == 1'b0, "R9 active dropped", v, 32'h0);
    reg_wr(3'd4, 32'd0);
    repeat (4) @(negedge clk);

    // R7 error on third source read
    push_exp(32'h40, 32'h380, 2, 2, 2, 1, 1);
    base = wr_cnt;
    err_addr = 32'h48;
    reg_wr(3'd0, 32'h40);
    reg_wr(3'd1, 32'h380);
    reg_wr(3'd3, mk_ctrl(4, 0, 0, 2, 2, 1, 1, 3'b000, 1));
    reg_wr(3'd4, mk_cfg(1, 0, 0, 0, 1, 0, 0, 0));
    wait_done();
    chk(wr_cnt - base == 2, "R7 stops at error", 32'(wr_cnt - base), 32'd2);
    reg_rd(3'd5, v); chk(v == 32'd2, "R7 error flag only", v, 32'd2);
    chk(irq_err == 1'b1, "R7 irq_err with mask", 32'(irq_err), 32'd1);
    reg_rd(3'd4, v); chk(v[0] == 1'b0, "R7 enable cleared", v, 32'd0);
    reg_wr(3'd6, 32'd2);
    reg_rd(3'd5, v); chk(v == 32'd0, "R8 error cleared", v, 32'd0);
    chk(irq_err == 1'b0, "R8 irq_err dropped", 32'(irq_err), 32'd0);
    err_addr = 32'hFFFF_FFFF;

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected writes seen", 32'(exp_q.size()), 32'd0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule